// File: doc/BRIEF.md
# Banked TLB Register Access Unit

This block sits between the special-register move path of a processor and a set-associative translation buffer. It holds a bank-select register and four banks of sixteen 32-bit special registers. Two of those banks (1 and 2) each own a private translation array of four sets with sixteen entries per set. In those two banks, some register writes and all register reads have side effects on the array.

Writing the high word register copies the value into the fault-cause register as well; that register is the staging place for the next entry's high word. Writing the low word register commits a full entry. The new low word is the written value and the new high word is the current fault-cause value. The slot is chosen by the select register. If the entry being replaced was valid, the block issues a one-cycle invalidate request carrying that old entry's virtual page address. Reads in a translation bank first reload the high and low mirror registers from the selected entry, then return the requested register one cycle later. Every read also clears all bank-select bits above the low two.

Top module: `tlb_sreg_unit`

## Requirements
- R1: The active bank is bank-select bits [1:0]. Array side effects (cause copy, commit, mirror reload) happen only in banks 1 and 2. In banks 0 and 3, writes and reads touch only the addressed register.
- R2: In bank 1 or 2, a write to register 6 (high word) stores the value in register 6 and in register 4 (fault cause) of that bank.
- R3: In bank 1 or 2, a write to register 5 (low word) stores the value in register 5. It also writes the entry {high = register 4, low = written value} into that bank's array.
- R4: The entry slot comes from register 3 (select): bits [5:4] pick the set and bits [3:0] pick the index.
- R5: On a commit, the old entry's low bit 3 is its valid flag. Only when that flag is 1 does the block request an invalidate, with address = old high word bits [31:13] followed by 13 zero bits.
- R6: The invalidate request is a single-cycle pulse, high in the cycle after the commit.
- R7: A read returns the addressed register of the active bank on rd_data, with rd_valid high, in the cycle after the request. In banks 1 and 2, registers 6 and 5 are first reloaded from the selected entry's high and low words, and the read returns the reloaded value.
- R8: A read leaves the bank-select register with only bits [1:0] kept and all higher bits cleared.
- R9: After reset, all registers, bank-select and every array entry are zero. The first commit to any slot therefore raises no invalidate.
- R10: Banks 1 and 2 keep separate arrays. A commit in one bank is not visible through reads in the other.
- R11: When several requests arrive in one cycle, a bank-select write wins over a register write, and a register write wins over a read. The losing requests have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bsel_wr_en | input | 1 | Write the bank-select register |
| bsel_wr_data | input | 32 | New bank-select value |
| sreg_wr_en | input | 1 | Write a special register in the active bank |
| sreg_rd_en | input | 1 | Read a special register in the active bank |
| sreg_num | input | 4 | Special register number |
| sreg_wdata | input | 32 | Special register write value |
| bsel_q | output | 32 | Current bank-select register |
| rd_data | output | 32 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result present this cycle |
| flush_req | output | 1 | Single-page invalidate pulse |
| flush_addr | output | 32 | Page address of the invalidate |

## Verification
The embedded properties assume one request per cycle. The priority rule makes overlaps legal, but the request-to-effect properties look only at requests that win arbitration. They also assume reset is driven low for at least one clock before any request. The bench's directed phase issues exactly one request per cycle. Its random phase picks exactly one of bank write, register write or read in each cycle, so the losing-request case of R11 is exercised only at the bench's own model level. The random register numbers are biased towards the select, cause, low and high registers, and the select values span all sets and indices.

// File: rtl/tlbsu_pkg.sv
package tlbsu_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_BANK  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } sreg_op_e;

   // Arbitration of one cycle's requests: bank write, then register write, then read.
   function automatic sreg_op_e pick_op(input logic bank_wr, input logic reg_wr,
                                        input logic reg_rd);
      if (bank_wr)     return OP_BANK;
      else if (reg_wr) return OP_WRITE;
      else if (reg_rd) return OP_READ;
      else             return OP_IDLE;
   endfunction

endpackage

// File: rtl/tlbsu_bank_sel.sv
module tlbsu_bank_sel #(
   parameter int DATA_W      = 32,
   parameter int BANK_W      = 2,
   parameter int TLB_BANK_LO = 1,
   parameter int TLB_BANKS   = 2,
   parameter int TB_W        = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              norm_en,
   output logic [DATA_W-1:0] bsel_q,
   output logic [BANK_W-1:0] bank,
   output logic              tlb_hit,
   output logic [TB_W-1:0]   tbank
);
   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << BANK_W) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)       bsel_q <= '0;
      else if (wr_en)   bsel_q <= wr_data;
      else if (norm_en) bsel_q <= bsel_q & KEEP_MASK;
   end

   assign bank    = bsel_q[BANK_W-1:0];
   assign tlb_hit = (int'(bank) >= TLB_BANK_LO) && (int'(bank) < TLB_BANK_LO + TLB_BANKS);
   assign tbank   = TB_W'(int'(bank) - TLB_BANK_LO);

   // R8: a read clears every bank-select bit above the bank field
   a_r8_read_normalises: assert property (@(posedge clk) disable iff (!rst_n)
      (norm_en && !wr_en) |=> (bsel_q[DATA_W-1:BANK_W] == '0));

endmodule

// File: rtl/tlbsu_sreg_file.sv
module tlbsu_sreg_file #(
   parameter int DATA_W    = 32,
   parameter int BANK_W    = 2,
   parameter int NUM_SREG  = 16,
   parameter int NUM_W     = 4,
   parameter int SEL_NUM   = 3,
   parameter int CAUSE_NUM = 4,
   parameter int LO_NUM    = 5,
   parameter int HI_NUM    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank,
   input  logic              tlb_hit,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [NUM_W-1:0]  num,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ent_hi,
   input  logic [DATA_W-1:0] ent_lo,
   output logic [DATA_W-1:0] sel_q,
   output logic [DATA_W-1:0] cause_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int NUM_BANKS = 1 << BANK_W;
   localparam logic [NUM_W-1:0] SEL_IDX   = NUM_W'(SEL_NUM);
   localparam logic [NUM_W-1:0] CAUSE_IDX = NUM_W'(CAUSE_NUM);
   localparam logic [NUM_W-1:0] LO_IDX    = NUM_W'(LO_NUM);
   localparam logic [NUM_W-1:0] HI_IDX    = NUM_W'(HI_NUM);

   logic [DATA_W-1:0] regs [NUM_BANKS][NUM_SREG];
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      if (tlb_hit && num == HI_IDX)      rd_mux = ent_hi;
      else if (tlb_hit && num == LO_IDX) rd_mux = ent_lo;
      else                               rd_mux = regs[bank][num];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BANKS; b++)
            for (int r = 0; r < NUM_SREG; r++)
               regs[b][r] <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en && !wr_en;
         if (wr_en) begin
            regs[bank][num] <= wdata;
            if (tlb_hit && num == HI_IDX)
               regs[bank][CAUSE_IDX] <= wdata;
         end else if (rd_en) begin
            if (tlb_hit) begin
               regs[bank][HI_IDX] <= ent_hi;
               regs[bank][LO_IDX] <= ent_lo;
            end
            rd_data <= rd_mux;
         end
      end
   end

   assign sel_q   = regs[bank][SEL_IDX];
   assign cause_q = regs[bank][CAUSE_IDX];

   // R2: a high-word write in a translation bank lands in the cause register too
   a_r2_cause_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tlb_hit && num == HI_IDX) |=> (regs[$past(bank)][CAUSE_IDX] == $past(wdata)));

   // R1: outside the translation banks the cause register is untouched by high-word writes
   a_r1_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tlb_hit && num == HI_IDX)
      |=> (regs[$past(bank)][CAUSE_IDX] == $past(regs[bank][CAUSE_IDX])));

   // R7: every winning read produces a result one cycle later
   a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> rd_valid);

endmodule

// File: rtl/tlbsu_entry_store.sv
module tlbsu_entry_store #(
   parameter int DATA_W    = 32,
   parameter int TLB_BANKS = 2,
   parameter int TB_W      = 1,
   parameter int ADDR_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [TB_W-1:0]   tbank,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] new_hi,
   input  logic [DATA_W-1:0] new_lo,
   output logic [DATA_W-1:0] cur_hi,
   output logic [DATA_W-1:0] cur_lo
);
   localparam int NUM_ENT = 1 << ADDR_W;

   logic [DATA_W-1:0] bank_hi [TLB_BANKS];
   logic [DATA_W-1:0] bank_lo [TLB_BANKS];

   for (genvar g = 0; g < TLB_BANKS; g++) begin : g_bank
      logic [DATA_W-1:0] hi_mem [NUM_ENT];
      logic [DATA_W-1:0] lo_mem [NUM_ENT];
      logic              wr_here;

      assign wr_here = commit && (int'(tbank) == g);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int e = 0; e < NUM_ENT; e++) begin
               hi_mem[e] <= '0;
               lo_mem[e] <= '0;
            end
         end else if (wr_here) begin
            hi_mem[addr] <= new_hi;
            lo_mem[addr] <= new_lo;
         end
      end

      assign bank_hi[g] = hi_mem[addr];
      assign bank_lo[g] = lo_mem[addr];
   end

   if (TLB_BANKS == 1) begin : g_single
      assign cur_hi = bank_hi[0];
      assign cur_lo = bank_lo[0];
   end else begin : g_multi
      assign cur_hi = bank_hi[tbank];
      assign cur_lo = bank_lo[tbank];
   end

   // R3: a committed entry reads back when the same slot stays selected
   a_r3_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (!$stable(addr) || !$stable(tbank)
                  || (cur_hi == $past(new_hi) && cur_lo == $past(new_lo))));

endmodule

// File: rtl/tlbsu_flush_gen.sv
module tlbsu_flush_gen #(
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 13,
   parameter int VALID_POS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [DATA_W-1:0] old_hi,
   input  logic [DATA_W-1:0] old_lo,
   output logic              flush_req,
   output logic [DATA_W-1:0] flush_addr
);
   logic old_valid;
   logic unused_bits;

   assign old_valid   = old_lo[VALID_POS];
   assign unused_bits = ^{old_hi[PAGE_SHIFT-1:0], old_lo};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_req  <= 1'b0;
         flush_addr <= '0;
      end else begin
         flush_req <= commit && old_valid;
         if (commit && old_valid)
            flush_addr <= {old_hi[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      end
   end

   // R6: a request only ever follows a commit by one cycle
   a_r6_pulse_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> $past(commit));

   // R5: replacing an invalid entry never requests an invalidate
   a_r5_invalid_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !old_valid) |=> !flush_req);

   // R5: the request address is page aligned
   a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> (flush_addr[PAGE_SHIFT-1:0] == '0));

endmodule

// File: rtl/tlb_sreg_unit.sv
module tlb_sreg_unit #(
   parameter int DATA_W      = 32,
   parameter int BANK_W      = 2,
   parameter int NUM_SREG    = 16,
   parameter int TLB_BANK_LO = 1,
   parameter int TLB_BANKS   = 2,
   parameter int SET_BITS    = 2,
   parameter int IDX_BITS    = 4,
   parameter int SET_LSB     = 4,
   parameter int PAGE_SHIFT  = 13,
   parameter int VALID_POS   = 3,
   parameter int SEL_NUM     = 3,
   parameter int CAUSE_NUM   = 4,
   parameter int LO_NUM      = 5,
   parameter int HI_NUM      = 6,
   localparam int NUM_W      = $clog2(NUM_SREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bsel_wr_en,
   input  logic [DATA_W-1:0] bsel_wr_data,
   input  logic              sreg_wr_en,
   input  logic              sreg_rd_en,
   input  logic [NUM_W-1:0]  sreg_num,
   input  logic [DATA_W-1:0] sreg_wdata,
   output logic [DATA_W-1:0] bsel_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              flush_req,
   output logic [DATA_W-1:0] flush_addr
);
   import tlbsu_pkg::*;

   localparam int TB_W   = (TLB_BANKS > 1) ? $clog2(TLB_BANKS) : 1;
   localparam int ADDR_W = SET_BITS + IDX_BITS;
   localparam logic [NUM_W-1:0] LO_IDX = NUM_W'(LO_NUM);

   // Elaboration-time parameter checks
   if (SET_LSB < IDX_BITS || SET_LSB + SET_BITS > DATA_W) begin : g_bad_sel
      $error("select fields overlap or exceed the data width");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= DATA_W || VALID_POS >= DATA_W) begin : g_bad_pos
      $error("page shift or valid position out of range");
   end
   if (TLB_BANK_LO + TLB_BANKS > (1 << BANK_W) || TLB_BANKS < 1) begin : g_bad_bank
      $error("translation banks exceed the bank space");
   end
   if (SEL_NUM >= NUM_SREG || CAUSE_NUM >= NUM_SREG || LO_NUM >= NUM_SREG
       || HI_NUM >= NUM_SREG) begin : g_bad_num
      $error("register number outside the register file");
   end
   if (SEL_NUM == CAUSE_NUM || SEL_NUM == LO_NUM || SEL_NUM == HI_NUM
       || CAUSE_NUM == LO_NUM || CAUSE_NUM == HI_NUM || LO_NUM == HI_NUM) begin : g_bad_dup
      $error("register numbers must be distinct");
   end

   sreg_op_e          op;
   logic              wr_go, rd_go, commit, tlb_hit;
   logic [BANK_W-1:0] bank;
   logic [TB_W-1:0]   tbank;
   logic [DATA_W-1:0] sel_q, cause_q, ent_hi, ent_lo;
   logic [ADDR_W-1:0] ent_addr;
   logic              unused_sel;

   assign op     = pick_op(bsel_wr_en, sreg_wr_en, sreg_rd_en);
   assign wr_go  = (op == OP_WRITE);
   assign rd_go  = (op == OP_READ);
   assign commit = wr_go && tlb_hit && (sreg_num == LO_IDX);

   assign ent_addr   = {sel_q[SET_LSB +: SET_BITS], sel_q[IDX_BITS-1:0]};
   assign unused_sel = ^sel_q;

   tlbsu_bank_sel #(
      .DATA_W(DATA_W), .BANK_W(BANK_W), .TLB_BANK_LO(TLB_BANK_LO),
      .TLB_BANKS(TLB_BANKS), .TB_W(TB_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(bsel_wr_en), .wr_data(bsel_wr_data),
      .norm_en(rd_go), .bsel_q(bsel_q), .bank(bank), .tlb_hit(tlb_hit), .tbank(tbank)
   );

   tlbsu_sreg_file #(
      .DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_SREG(NUM_SREG), .NUM_W(NUM_W),
      .SEL_NUM(SEL_NUM), .CAUSE_NUM(CAUSE_NUM), .LO_NUM(LO_NUM), .HI_NUM(HI_NUM)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bank(bank), .tlb_hit(tlb_hit),
      .wr_en(wr_go), .rd_en(rd_go), .num(sreg_num), .wdata(sreg_wdata),
      .ent_hi(ent_hi), .ent_lo(ent_lo), .sel_q(sel_q), .cause_q(cause_q),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   tlbsu_entry_store #(
      .DATA_W(DATA_W), .TLB_BANKS(TLB_BANKS), .TB_W(TB_W), .ADDR_W(ADDR_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .commit(commit), .tbank(tbank), .addr(ent_addr),
      .new_hi(cause_q), .new_lo(sreg_wdata), .cur_hi(ent_hi), .cur_lo(ent_lo)
   );

   tlbsu_flush_gen #(
      .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT), .VALID_POS(VALID_POS)
   ) u_flush (
      .clk(clk), .rst_n(rst_n), .commit(commit), .old_hi(ent_hi), .old_lo(ent_lo),
      .flush_req(flush_req), .flush_addr(flush_addr)
   );

   // R11: a losing register write or read leaves the read port quiet
   a_r11_bank_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      bsel_wr_en |=> !rd_valid);

endmodule

// File: tb/sim_tlb_sreg_unit.sv
`timescale 1ns/1ps
module sim_tlb_sreg_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bsel_wr_en = 1'b0, sreg_wr_en = 1'b0, sreg_rd_en = 1'b0;
   logic [31:0] bsel_wr_data = '0, sreg_wdata = '0;
   logic [3:0]  sreg_num = '0;
   logic [31:0] bsel_q, rd_data, flush_addr;
   logic        rd_valid, flush_req;

   int nchk = 0, nerr = 0;
   bit done = 0;

   // Reference state
   logic [31:0] m_reg [4][16];
   logic [31:0] m_hi  [2][64];
   logic [31:0] m_lo  [2][64];
   logic [31:0] m_bsel, e_addr, e_rd;
   logic        e_flush, e_valid;

   always #2 clk = ~clk;

   tlb_sreg_unit u0 (
      .clk(clk), .rst_n(rst_n), .bsel_wr_en(bsel_wr_en), .bsel_wr_data(bsel_wr_data),
      .sreg_wr_en(sreg_wr_en), .sreg_rd_en(sreg_rd_en), .sreg_num(sreg_num),
      .sreg_wdata(sreg_wdata), .bsel_q(bsel_q), .rd_data(rd_data), .rd_valid(rd_valid),
      .flush_req(flush_req), .flush_addr(flush_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock of the reference: bank write > register write > read
   task automatic model_tick();
      int b, slot, t;
      e_flush = 1'b0;
      e_valid = 1'b0;
      if (bsel_wr_en) begin
         m_bsel = bsel_wr_data;
      end else if (sreg_wr_en) begin
         b = int'(m_bsel & 32'h3);
         m_reg[b][sreg_num] = sreg_wdata;
         if (b == 1 || b == 2) begin
            if (sreg_num == 4'd6) m_reg[b][4] = sreg_wdata;
            else if (sreg_num == 4'd5) begin
               t = b - 1;
               slot = int'(((m_reg[b][3] >> 4) & 32'h3) * 16 + (m_reg[b][3] & 32'hF));
               if (m_lo[t][slot][3]) begin
                  e_flush = 1'b1;
                  e_addr  = m_hi[t][slot] & 32'hFFFF_E000;
               end
               m_hi[t][slot] = m_reg[b][4];
               m_lo[t][slot] = sreg_wdata;
            end
         end
      end else if (sreg_rd_en) begin
         m_bsel = m_bsel & 32'h3;
         b = int'(m_bsel);
         if (b == 1 || b == 2) begin
            t = b - 1;
            slot = int'(((m_reg[b][3] >> 4) & 32'h3) * 16 + (m_reg[b][3] & 32'hF));
            m_reg[b][6] = m_hi[t][slot];
            m_reg[b][5] = m_lo[t][slot];
         end
         e_valid = 1'b1;
         e_rd    = m_reg[b][sreg_num];
      end
   endtask

   task automatic compare();
      chk("R6 flush pulse", {31'd0, flush_req}, {31'd0, e_flush});
      if (e_flush) chk("R5 flush address", flush_addr, e_addr);
      chk("R7 read valid", {31'd0, rd_valid}, {31'd0, e_valid});
      if (e_valid) chk("R7 read data", rd_data, e_rd);
      chk("R8 bank select", bsel_q, m_bsel);
   endtask

   task automatic step(input logic bw, input logic [31:0] bd, input logic w,
                       input logic r, input logic [3:0] n, input logic [31:0] d);
      bsel_wr_en = bw; bsel_wr_data = bd;
      sreg_wr_en = w;  sreg_rd_en = r; sreg_num = n; sreg_wdata = d;
      @(posedge clk);
      model_tick();
      @(negedge clk);
      bsel_wr_en = 1'b0; sreg_wr_en = 1'b0; sreg_rd_en = 1'b0;
      compare();
   endtask

   task automatic set_bank(input logic [31:0] v);
      step(1'b1, v, 1'b0, 1'b0, 4'd0, 32'd0);
   endtask
   task automatic wr(input logic [3:0] n, input logic [31:0] d);
      step(1'b0, 32'd0, 1'b1, 1'b0, n, d);
   endtask
   task automatic rd_expect(input logic [3:0] n, input logic [31:0] ev, input string tag);
      step(1'b0, 32'd0, 1'b0, 1'b1, n, 32'd0);
      chk(tag, rd_data, ev);
   endtask

   initial begin
      for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) m_reg[b][r] = '0;
      for (int t = 0; t < 2; t++) for (int e = 0; e < 64; e++) begin
         m_hi[t][e] = '0; m_lo[t][e] = '0;
      end
      m_bsel = '0; e_flush = 0; e_valid = 0; e_addr = '0; e_rd = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      chk("R9 reset bank select", bsel_q, 32'd0);
      chk("R9 reset flush", {31'd0, flush_req}, 32'd0);
      chk("R9 reset read valid", {31'd0, rd_valid}, 32'd0);

      // Bank 1, slot set 2 index 5
      set_bank(32'd1);
      wr(4'd3, 32'h0000_0025);
      wr(4'd6, 32'h1234_6000);
      rd_expect(4'd4, 32'h1234_6000, "R2 cause copy");
      wr(4'd5, 32'h0000_0008);
      chk("R9 first commit no flush", {31'd0, flush_req}, 32'd0);
      rd_expect(4'd6, 32'h1234_6000, "R3 entry high word");
      rd_expect(4'd5, 32'h0000_0008, "R3 entry low word");

      // Overwrite the valid entry: invalidate of old page
      wr(4'd6, 32'hFEDC_A123);
      wr(4'd5, 32'h0000_0010);
      chk("R5 flush raised", {31'd0, flush_req}, 32'd1);
      chk("R5 flush page", flush_addr, 32'h1234_6000);
      step(1'b0, 32'd0, 1'b0, 1'b0, 4'd0, 32'd0);
      chk("R6 single cycle pulse", {31'd0, flush_req}, 32'd0);

      // Overwrite an invalid entry: no invalidate
      wr(4'd5, 32'h0000_0018);
      chk("R5 invalid old entry", {31'd0, flush_req}, 32'd0);

      // Different slot, then come back
      wr(4'd3, 32'h0000_000F);
      wr(4'd6, 32'hAAAA_0000);
      wr(4'd5, 32'h0000_0001);
      rd_expect(4'd6, 32'hAAAA_0000, "R4 set 0 index 15 high");
      wr(4'd3, 32'h0000_0025);
      rd_expect(4'd6, 32'hFEDC_A123, "R4 set 2 index 5 kept");

      // Bank 2 array is separate
      set_bank(32'd2);
      wr(4'd3, 32'h0000_0025);
      rd_expect(4'd6, 32'h0000_0000, "R10 bank 2 untouched");
      rd_expect(4'd5, 32'h0000_0000, "R10 bank 2 low untouched");

      // Bank 0: no side effects
      set_bank(32'd0);
      wr(4'd6, 32'h0000_0055);
      rd_expect(4'd4, 32'h0000_0000, "R1 bank 0 no cause copy");
      rd_expect(4'd6, 32'h0000_0055, "R1 bank 0 plain register");

      // Bank-select normalisation
      set_bank(32'hFFFF_FFF1);
      chk("R8 before read", bsel_q, 32'hFFFF_FFF1);
      rd_expect(4'd6, 32'hFEDC_A123, "R7 bank 1 mirror reload");
      chk("R8 normalised", bsel_q, 32'h0000_0001);

      // Priority: bank write beats register write and read
      step(1'b1, 32'd2, 1'b1, 1'b1, 4'd6, 32'h7777_7777);
      chk("R11 read suppressed", {31'd0, rd_valid}, 32'd0);
      rd_expect(4'd4, 32'h0000_0000, "R11 write suppressed");

      // Random traffic against the model
      for (int k = 0; k < 600; k++) begin
         int op;
         logic [3:0] n;
         op = int'($urandom % 10);
         case ($urandom % 6)
            0: n = 4'd3;
            1: n = 4'd4;
            2: n = 4'd5;
            3: n = 4'd6;
            default: n = 4'($urandom % 16);
         endcase
         if (op == 0)
            set_bank(($urandom % 3 == 0) ? $urandom : ($urandom % 4));
         else if (op < 6)
            wr(n, (n == 4'd3) ? ($urandom & 32'h3F) : $urandom);
         else
            step(1'b0, 32'd0, 1'b0, 1'b1, n, 32'd0);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule